// File: doc/BRIEF.md
# Prescaled 64-bit Alarm Timer

This block is one general-purpose timer channel. A 64-bit counter steps up or down once every N clock cycles. N comes from a programmable divide-by-N prescaler. A 64-bit comparator watches the counter. When the counter equals the programmed alarm value and the alarm is armed, the block produces a one-cycle alarm event pulse and latches an interrupt flag. It can optionally reload the counter from a 64-bit preset value in that same step. Software drives the block through a flat, word-addressed register port: writes are synchronous and reads are combinational.

The live counter cannot be read directly. Software first requests a snapshot. A busy bit stays high while the request travels through a short synchroniser, and the counter value is copied into two readback words once the bit drops. Besides the register port, the block accepts five single-cycle hardware strobes from neighbouring logic: start, stop, arm, reload and snapshot. They act alongside register writes and win over a write that lands in the same cycle.

Register map (word addresses): 0 control, 1 snapshot request/busy, 2 and 3 snapshot low/high, 4 and 5 alarm low/high, 6 and 7 preset low/high, 8 preset-now trigger, 9 interrupt enable, 10 raw interrupt, 11 interrupt clear, 12 masked interrupt. Control word bits: bit 0 run, bit 1 count direction (1 = up, 0 = down), bit 2 reload-on-alarm, bit 3 alarm armed, bits 31:16 divider code.

Top module: `alarm_timer64`

## Requirements
- R1: After reset the control word reads 0x0002_0000 (divider code 2, everything else off). The snapshot words, busy bit and raw interrupt read 0, and both outputs are low.
- R2: With divider code N (2..65535) the counter steps once every N clocks. Code 0 means a ratio of 65536. Any write to the control word restarts the prescaler phase, so the first step lands N clocks after the write edge.
- R3: The counter counts up when control bit 1 is 1 and down when it is 0. It wraps modulo 2^64 in both directions.
- R4: Control bit 0 gates counting. The stop strobe clears it and the start strobe sets it. Stop wins over start, and a strobe wins over a control write in the same cycle.
- R5: While armed (control bit 3), a counter equal to the alarm value causes `evt_alarm_o` to pulse for one cycle on the next clock edge. The armed bit clears itself on that edge. It is re-armed by a control write or by the arm strobe, and the arm strobe wins over a control write that clears the bit.
- R6: With reload-on-alarm set (control bit 2), the counter takes the preset value on the edge after the match, instead of stepping.
- R7: Writing 1 to bit 0 of address 8, or pulsing the reload strobe, copies the 64-bit preset into the counter on that clock edge.
- R8: Writing 1 to bit 0 of address 1, or pulsing the snapshot strobe, sets the busy bit (address 1, bit 0) for exactly two cycles. When the bit drops, addresses 2 and 3 hold the counter's low and high words.
- R9: The raw interrupt (address 10, bit 0) is set by every alarm and cleared by writing 1 to bit 0 of address 11. `irq_o` and address 12 show the raw flag ANDed with bit 0 of address 9.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| wr_en_i | input | 1 | Register write strobe |
| wr_addr_i | input | 4 | Register write word address |
| wr_data_i | input | 32 | Register write data |
| rd_addr_i | input | 4 | Register read word address |
| rd_data_o | output | 32 | Register read data (combinational) |
| task_start_i | input | 1 | Strobe: start counting |
| task_stop_i | input | 1 | Strobe: stop counting |
| task_arm_i | input | 1 | Strobe: arm the alarm |
| task_reload_i | input | 1 | Strobe: load the preset into the counter |
| task_capture_i | input | 1 | Strobe: request a snapshot |
| evt_alarm_o | output | 1 | One-cycle alarm match pulse |
| irq_o | output | 1 | Masked interrupt |

## Verification
The hardest situation to reach from the ports is a counter state just after an alarm: after a reload-on-alarm step, after a down-count through zero, or after a ratio-65536 wait. The live count is visible only through the delayed snapshot. The stimulus therefore predicts the exact cycle of every alarm pulse from the divider code and the distance to the alarm value, and queues it. It fires the stop strobe in that very cycle, so the frozen counter value follows from the ratio and the prescaler phase. A snapshot of that value is then compared against the computed result.

// File: rtl/tmr_pkg.sv
package tmr_pkg;
   localparam int unsigned DATA_W = 32;
   localparam int unsigned ADDR_W = 4;

   // word addresses
   localparam logic [ADDR_W-1:0] A_CTRL     = 4'd0;
   localparam logic [ADDR_W-1:0] A_SNAP     = 4'd1;
   localparam logic [ADDR_W-1:0] A_SNAP_LO  = 4'd2;
   localparam logic [ADDR_W-1:0] A_SNAP_HI  = 4'd3;
   localparam logic [ADDR_W-1:0] A_ALARM_LO = 4'd4;
   localparam logic [ADDR_W-1:0] A_ALARM_HI = 4'd5;
   localparam logic [ADDR_W-1:0] A_LOAD_LO  = 4'd6;
   localparam logic [ADDR_W-1:0] A_LOAD_HI  = 4'd7;
   localparam logic [ADDR_W-1:0] A_LOAD_GO  = 4'd8;
   localparam logic [ADDR_W-1:0] A_IRQ_EN   = 4'd9;
   localparam logic [ADDR_W-1:0] A_IRQ_RAW  = 4'd10;
   localparam logic [ADDR_W-1:0] A_IRQ_CLR  = 4'd11;
   localparam logic [ADDR_W-1:0] A_IRQ_STAT = 4'd12;

   // control word bit positions
   localparam int unsigned B_RUN = 0;
   localparam int unsigned B_UP  = 1;
   localparam int unsigned B_ARL = 2;
   localparam int unsigned B_ARM = 3;
   localparam int unsigned B_DIV = 16;
endpackage

// File: rtl/tmr_prescale.sv
module tmr_prescale #(
   parameter int unsigned DIV_W = 16
) (
   input  logic             clk_i,
   input  logic             rst_ni,
   input  logic             run_i,
   input  logic             phase_clr_i,
   input  logic [DIV_W-1:0] code_i,
   output logic             tick_o
);
   logic [DIV_W-1:0] ratio_m1;
   logic [DIV_W-1:0] pcnt_q;

   // code 0 stands for 2^DIV_W
   assign ratio_m1 = (code_i == '0) ? '1 : code_i - DIV_W'(1);
   assign tick_o   = run_i && (pcnt_q == ratio_m1);

   always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni)          pcnt_q <= '0;
      else if (phase_clr_i) pcnt_q <= '0;
      else if (run_i)       pcnt_q <= tick_o ? '0 : pcnt_q + DIV_W'(1);
   end
endmodule

// File: rtl/tmr_counter.sv
module tmr_counter #(
   parameter int unsigned CNT_W = 64
) (
   input  logic             clk_i,
   input  logic             rst_ni,
   input  logic             tick_i,
   input  logic             up_i,
   input  logic             load_now_i,
   input  logic             auto_rl_i,
   input  logic             arm_i,
   input  logic [CNT_W-1:0] alarm_i,
   input  logic [CNT_W-1:0] preset_i,
   output logic [CNT_W-1:0] cnt_o,
   output logic             hit_o
);
   logic [CNT_W-1:0] cnt_q;

   assign hit_o = arm_i && (cnt_q == alarm_i);
   assign cnt_o = cnt_q;

   always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni)                  cnt_q <= '0;
      else if (load_now_i)          cnt_q <= preset_i;
      else if (hit_o && auto_rl_i)  cnt_q <= preset_i;
      else if (tick_i)              cnt_q <= up_i ? cnt_q + CNT_W'(1) : cnt_q - CNT_W'(1);
   end
endmodule

// File: rtl/tmr_capture.sv
module tmr_capture #(
   parameter int unsigned CNT_W  = 64,
   parameter int unsigned STAGES = 2
) (
   input  logic             clk_i,
   input  logic             rst_ni,
   input  logic             start_i,
   input  logic [CNT_W-1:0] live_i,
   output logic             busy_o,
   output logic [CNT_W-1:0] snap_o
);
   logic [STAGES-1:0] sh_q;
   logic [STAGES-1:0] sh_d;
   logic              busy_q;
   logic [CNT_W-1:0]  snap_q;

   generate
      if (STAGES == 1) begin : g_one
         assign sh_d = start_i;
      end else begin : g_many
         assign sh_d = {sh_q[STAGES-2:0], start_i};
      end
   endgenerate

   always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) begin
         sh_q   <= '0;
         busy_q <= 1'b0;
         snap_q <= '0;
      end else begin
         sh_q <= sh_d;
         if (start_i)               busy_q <= 1'b1;
         else if (sh_q[STAGES-1])   busy_q <= 1'b0;
         if (sh_q[STAGES-1])        snap_q <= live_i;
      end
   end

   assign busy_o = busy_q;
   assign snap_o = snap_q;
endmodule

// File: rtl/alarm_timer64.sv
module alarm_timer64
   import tmr_pkg::*;
#(
   parameter int unsigned CNT_W       = 64,
   parameter int unsigned DIV_W       = 16,
   parameter int unsigned DIV_RST     = 2,
   parameter int unsigned SYNC_STAGES = 2
) (
   input  logic              clk_i,
   input  logic              rst_ni,
   input  logic              wr_en_i,
   input  logic [ADDR_W-1:0] wr_addr_i,
   input  logic [DATA_W-1:0] wr_data_i,
   input  logic [ADDR_W-1:0] rd_addr_i,
   output logic [DATA_W-1:0] rd_data_o,
   input  logic              task_start_i,
   input  logic              task_stop_i,
   input  logic              task_arm_i,
   input  logic              task_reload_i,
   input  logic              task_capture_i,
   output logic              evt_alarm_o,
   output logic              irq_o
);
   localparam int unsigned PAD_W = 2 * DATA_W;
   localparam int unsigned NWORD = 2;

   generate
      if (CNT_W <= DATA_W || CNT_W > PAD_W) begin : g_bad_cnt
         $error("CNT_W must lie in (DATA_W, 2*DATA_W]");
      end
      if (DIV_W < 2 || DIV_W > DATA_W - B_DIV) begin : g_bad_div
         $error("DIV_W must fit the control divider field");
      end
      if (DIV_RST < 2 || DIV_RST >= (1 << DIV_W)) begin : g_bad_rst
         $error("DIV_RST must be a legal divider code");
      end
      if (SYNC_STAGES < 1) begin : g_bad_sync
         $error("SYNC_STAGES must be at least 1");
      end
   endgenerate

   logic             run_q, up_q, arl_q, arm_q, irq_en_q, irq_raw_q, evt_q;
   logic [DIV_W-1:0] div_q;
   logic [PAD_W-1:0] alarm_q, load_q, snap_pad;
   logic [CNT_W-1:0] cnt_w, snap_w, load_val_w;
   logic             tick_w, hit_w, busy_w;
   logic             wr_ctrl, load_now, snap_start, irq_clr;

   assign wr_ctrl    = wr_en_i && (wr_addr_i == A_CTRL);
   assign load_now   = task_reload_i  || (wr_en_i && (wr_addr_i == A_LOAD_GO) && wr_data_i[0]);
   assign snap_start = task_capture_i || (wr_en_i && (wr_addr_i == A_SNAP) && wr_data_i[0]);
   assign irq_clr    = wr_en_i && (wr_addr_i == A_IRQ_CLR) && wr_data_i[0];
   assign load_val_w = load_q[CNT_W-1:0];

   // 32-bit halves of the alarm and preset registers
   generate
      for (genvar gk = 0; gk < NWORD; gk++) begin : g_word
         localparam logic [ADDR_W-1:0] AAL = A_ALARM_LO + ADDR_W'(gk);
         localparam logic [ADDR_W-1:0] ALD = A_LOAD_LO  + ADDR_W'(gk);
         logic [DATA_W-1:0] al_q, ld_q;
         always_ff @(posedge clk_i or negedge rst_ni) begin
            if (!rst_ni) begin
               al_q <= '0;
               ld_q <= '0;
            end else begin
               if (wr_en_i && wr_addr_i == AAL) al_q <= wr_data_i;
               if (wr_en_i && wr_addr_i == ALD) ld_q <= wr_data_i;
            end
         end
         assign alarm_q[gk*DATA_W +: DATA_W] = al_q;
         assign load_q [gk*DATA_W +: DATA_W] = ld_q;
      end
   endgenerate

   always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) begin
         run_q     <= 1'b0;
         up_q      <= 1'b0;
         arl_q     <= 1'b0;
         arm_q     <= 1'b0;
         div_q     <= DIV_W'(DIV_RST);
         irq_en_q  <= 1'b0;
         irq_raw_q <= 1'b0;
         evt_q     <= 1'b0;
      end else begin
         if (wr_ctrl) begin
            up_q  <= wr_data_i[B_UP];
            arl_q <= wr_data_i[B_ARL];
            div_q <= wr_data_i[B_DIV +: DIV_W];
         end
         if (task_stop_i)       run_q <= 1'b0;
         else if (task_start_i) run_q <= 1'b1;
         else if (wr_ctrl)      run_q <= wr_data_i[B_RUN];

         if (hit_w)             arm_q <= 1'b0;
         else if (task_arm_i)   arm_q <= 1'b1;
         else if (wr_ctrl)      arm_q <= wr_data_i[B_ARM];

         if (wr_en_i && wr_addr_i == A_IRQ_EN) irq_en_q <= wr_data_i[0];
         if (hit_w)             irq_raw_q <= 1'b1;
         else if (irq_clr)      irq_raw_q <= 1'b0;

         evt_q <= hit_w;
      end
   end

   tmr_prescale #(.DIV_W(DIV_W)) i_prescale (
      .clk_i       (clk_i),
      .rst_ni      (rst_ni),
      .run_i       (run_q),
      .phase_clr_i (wr_ctrl),
      .code_i      (div_q),
      .tick_o      (tick_w)
   );

   tmr_counter #(.CNT_W(CNT_W)) i_counter (
      .clk_i      (clk_i),
      .rst_ni     (rst_ni),
      .tick_i     (tick_w),
      .up_i       (up_q),
      .load_now_i (load_now),
      .auto_rl_i  (arl_q),
      .arm_i      (arm_q),
      .alarm_i    (alarm_q[CNT_W-1:0]),
      .preset_i   (load_val_w),
      .cnt_o      (cnt_w),
      .hit_o      (hit_w)
   );

   tmr_capture #(.CNT_W(CNT_W), .STAGES(SYNC_STAGES)) i_capture (
      .clk_i   (clk_i),
      .rst_ni  (rst_ni),
      .start_i (snap_start),
      .live_i  (cnt_w),
      .busy_o  (busy_w),
      .snap_o  (snap_w)
   );

   always_comb begin
      snap_pad = '0;
      snap_pad[CNT_W-1:0] = snap_w;
   end

   always_comb begin
      rd_data_o = '0;
      case (rd_addr_i)
         A_CTRL: begin
            rd_data_o[B_RUN]          = run_q;
            rd_data_o[B_UP]           = up_q;
            rd_data_o[B_ARL]          = arl_q;
            rd_data_o[B_ARM]          = arm_q;
            rd_data_o[B_DIV +: DIV_W] = div_q;
         end
         A_SNAP:     rd_data_o[0] = busy_w;
         A_SNAP_LO:  rd_data_o    = snap_pad[DATA_W-1:0];
         A_SNAP_HI:  rd_data_o    = snap_pad[PAD_W-1:DATA_W];
         A_ALARM_LO: rd_data_o    = alarm_q[DATA_W-1:0];
         A_ALARM_HI: rd_data_o    = alarm_q[PAD_W-1:DATA_W];
         A_LOAD_LO:  rd_data_o    = load_q[DATA_W-1:0];
         A_LOAD_HI:  rd_data_o    = load_q[PAD_W-1:DATA_W];
         A_IRQ_EN:   rd_data_o[0] = irq_en_q;
         A_IRQ_RAW:  rd_data_o[0] = irq_raw_q;
         A_IRQ_STAT: rd_data_o[0] = irq_raw_q & irq_en_q;
         default:    rd_data_o    = '0;
      endcase
   end

   assign evt_alarm_o = evt_q;
   assign irq_o       = irq_raw_q & irq_en_q;
endmodule

// File: rtl/tmr_checker.sv
module tmr_checker #(
   parameter int unsigned CNT_W = 64
) (
   input logic             clk_i,
   input logic             rst_ni,
   input logic             evt,
   input logic             hit,
   input logic             arm,
   input logic             run,
   input logic             stop,
   input logic             busy,
   input logic             irq_raw,
   input logic             arl,
   input logic             load_now,
   input logic [CNT_W-1:0] cnt,
   input logic [CNT_W-1:0] load_val
);
   AST_EVT_SINGLE:    assert property (@(posedge clk_i) disable iff (!rst_ni) evt |=> !evt);              // R5
   AST_ARM_CLEARS:    assert property (@(posedge clk_i) disable iff (!rst_ni) hit |=> !arm);              // R5
   AST_STOP_WINS:     assert property (@(posedge clk_i) disable iff (!rst_ni) stop |=> !run);             // R4
   AST_AUTO_RELOAD:   assert property (@(posedge clk_i) disable iff (!rst_ni)
                         (hit && arl && !load_now) |=> cnt == $past(load_val));                           // R6
   AST_SOFT_RELOAD:   assert property (@(posedge clk_i) disable iff (!rst_ni)
                         load_now |=> cnt == $past(load_val));                                            // R7
   AST_BUSY_HOLDS:    assert property (@(posedge clk_i) disable iff (!rst_ni) $rose(busy) |=> busy);      // R8
   AST_RAW_FROM_HIT:  assert property (@(posedge clk_i) disable iff (!rst_ni) $rose(irq_raw) |-> $past(hit)); // R9
   AST_EVT_SETS_RAW:  assert property (@(posedge clk_i) disable iff (!rst_ni) evt |-> irq_raw);           // R9
endmodule

bind alarm_timer64 tmr_checker #(.CNT_W(CNT_W)) i_chk (
   .clk_i    (clk_i),
   .rst_ni   (rst_ni),
   .evt      (evt_q),
   .hit      (hit_w),
   .arm      (arm_q),
   .run      (run_q),
   .stop     (task_stop_i),
   .busy     (busy_w),
   .irq_raw  (irq_raw_q),
   .arl      (arl_q),
   .load_now (load_now),
   .cnt      (cnt_w),
   .load_val (load_val_w)
);

// File: tb/test_alarm_timer64.sv
module test_alarm_timer64;
   import tmr_pkg::*;

   logic        clk = 1'b0;
   logic        rst_n;
   logic        wr_en;
   logic [3:0]  wr_addr, rd_addr;
   logic [31:0] wr_data, rd_data;
   logic        t_start, t_stop, t_arm, t_reload, t_cap;
   logic        evt, irq;

   int cyc = 0;
   int n_chk = 0;
   int n_bad = 0;
   int exp_evt[$];

   always #4 clk = ~clk;
   always @(posedge clk) cyc <= cyc + 1;

   alarm_timer64 i_alarm_timer64 (
      .clk_i(clk), .rst_ni(rst_n),
      .wr_en_i(wr_en), .wr_addr_i(wr_addr), .wr_data_i(wr_data),
      .rd_addr_i(rd_addr), .rd_data_o(rd_data),
      .task_start_i(t_start), .task_stop_i(t_stop), .task_arm_i(t_arm),
      .task_reload_i(t_reload), .task_capture_i(t_cap),
      .evt_alarm_o(evt), .irq_o(irq)
   );

   task automatic chk(input string req, input logic [63:0] act, input logic [63:0] exp);
      n_chk++;
      if (act !== exp) begin
         n_bad++;
         $display("FAIL %s: actual %0h expected %0h", req, act, exp);
      end
   endtask

   task automatic summary();
      $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
   endtask

   // scoreboard monitor: every alarm pulse must match the next predicted cycle
   always @(negedge clk) begin
      if (rst_n && evt) begin
         if (exp_evt.size() == 0) chk("R5 unexpected alarm pulse", 64'(cyc), 64'hFFFF);
         else chk("R2 R5 alarm cycle", 64'(cyc), 64'(exp_evt.pop_front()));
      end
   end

   task automatic wrx(input logic [3:0] a, input logic [31:0] d,
                      input logic s, input logic p, input logic m);
      wr_en = 1'b1; wr_addr = a; wr_data = d;
      t_start = s; t_stop = p; t_arm = m;
      @(negedge clk);
      wr_en = 1'b0; t_start = 1'b0; t_stop = 1'b0; t_arm = 1'b0;
   endtask

   task automatic wr(input logic [3:0] a, input logic [31:0] d);
      wrx(a, d, 1'b0, 1'b0, 1'b0);
   endtask

   task automatic rd(input logic [3:0] a, output logic [31:0] v);
      rd_addr = a;
      #1;
      v = rd_data;
   endtask

   task automatic strobe(input logic s, input logic p, input logic m, input logic r, input logic c);
      t_start = s; t_stop = p; t_arm = m; t_reload = r; t_cap = c;
      @(negedge clk);
      t_start = 1'b0; t_stop = 1'b0; t_arm = 1'b0; t_reload = 1'b0; t_cap = 1'b0;
   endtask

   task automatic prep(input logic [63:0] preset, input logic [63:0] alarm);
      wr(A_ALARM_LO, alarm[31:0]);
      wr(A_ALARM_HI, alarm[63:32]);
      wr(A_LOAD_LO, preset[31:0]);
      wr(A_LOAD_HI, preset[63:32]);
      wr(A_LOAD_GO, 32'h1);
   endtask

   // driver: predicts the alarm cycle, starts the run, stops it on the pulse
   task automatic fire(input logic [31:0] ctrl, input logic arm_t, input int delta);
      int tgt;
      tgt = cyc + 2 + delta;
      exp_evt.push_back(tgt);
      wrx(A_CTRL, ctrl, 1'b0, 1'b0, arm_t);
      while (cyc < tgt) @(negedge clk);
      strobe(1'b0, 1'b1, 1'b0, 1'b0, 1'b0);
   endtask

   task automatic snap_check(input string req, input logic [63:0] exp);
      logic [31:0] v, lo, hi;
      wr(A_SNAP, 32'h1);
      rd(A_SNAP, v);
      chk("R8 busy after request", 64'(v), 64'h1);
      @(negedge clk);
      @(negedge clk);
      rd(A_SNAP, v);
      chk("R8 busy cleared", 64'(v), 64'h0);
      rd(A_SNAP_LO, lo);
      rd(A_SNAP_HI, hi);
      chk(req, {hi, lo}, exp);
   endtask

   initial begin
      repeat (190000) @(posedge clk);
      n_chk++;
      n_bad++;
      $display("FAIL watchdog: actual timeout expected completion");
      summary();
      $finish;
   end

   initial begin
      logic [31:0] v, lo, hi;
      rst_n = 1'b0; wr_en = 1'b0; wr_addr = '0; wr_data = '0; rd_addr = '0;
      t_start = 1'b0; t_stop = 1'b0; t_arm = 1'b0; t_reload = 1'b0; t_cap = 1'b0;
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);

      // R1 reset state
      rd(A_CTRL, v);    chk("R1 control reset", 64'(v), 64'h0002_0000);
      rd(A_SNAP, v);    chk("R1 busy reset", 64'(v), 64'h0);
      rd(A_SNAP_LO, v); chk("R1 snapshot reset", 64'(v), 64'h0);
      rd(A_IRQ_RAW, v); chk("R1 raw irq reset", 64'(v), 64'h0);
      chk("R1 outputs reset", {62'h0, evt, irq}, 64'h0);

      // R2 R3 R5: up count 10 -> 14, ratio 2
      prep(64'd10, 64'd14);
      fire(32'h0002_000B, 1'b0, 8);
      rd(A_CTRL, v); chk("R5 arm self-clear and R4 stop", 64'(v), 64'h0002_0002);
      snap_check("R3 up count after alarm", 64'd15);

      // R9 interrupt flag, mask, clear
      rd(A_IRQ_RAW, v); chk("R9 raw set", 64'(v), 64'h1);
      chk("R9 masked off", 64'(irq), 64'h0);
      wr(A_IRQ_EN, 32'h1);
      chk("R9 masked on", 64'(irq), 64'h1);
      rd(A_IRQ_STAT, v); chk("R9 status word", 64'(v), 64'h1);
      wr(A_IRQ_CLR, 32'h1);
      chk("R9 cleared irq", 64'(irq), 64'h0);
      rd(A_IRQ_RAW, v); chk("R9 raw cleared", 64'(v), 64'h0);

      // R3 down count through zero, 64-bit alarm
      prep(64'd1, 64'hFFFF_FFFF_FFFF_FFFF);
      fire(32'h0002_0009, 1'b0, 4);
      snap_check("R3 down wrap", 64'hFFFF_FFFF_FFFF_FFFE);
      chk("R9 irq after alarm", 64'(irq), 64'h1);
      wr(A_IRQ_CLR, 32'h1);

      // R6 reload on alarm, ratio 3, down 100 -> 95
      prep(64'd100, 64'd95);
      fire(32'h0003_000D, 1'b0, 15);
      snap_check("R6 reloaded on alarm", 64'd100);
      // R5 R4 arm strobe beats a control write that leaves arm clear
      fire(32'h0003_0005, 1'b1, 15);
      snap_check("R5 strobe re-arm", 64'd100);

      // R2 code 0 is ratio 65536
      prep(64'd0, 64'd1);
      fire(32'h0000_000B, 1'b0, 65536);
      snap_check("R2 ratio 65536", 64'd1);

      // R4 priorities
      strobe(1'b1, 1'b1, 1'b0, 1'b0, 1'b0);
      rd(A_CTRL, v); chk("R4 stop beats start", 64'(v[0]), 64'h0);
      wrx(A_CTRL, 32'h0002_0001, 1'b0, 1'b1, 1'b0);
      rd(A_CTRL, v); chk("R4 stop beats write", 64'(v[0]), 64'h0);
      strobe(1'b1, 1'b0, 1'b0, 1'b0, 1'b0);
      rd(A_CTRL, v); chk("R4 start strobe", 64'(v[0]), 64'h1);
      strobe(1'b0, 1'b1, 1'b0, 1'b0, 1'b0);

      // R7 register-triggered preset
      prep(64'h1234_5678_9ABC_DEF0, 64'h0);
      snap_check("R7 preset by write", 64'h1234_5678_9ABC_DEF0);

      // R7 R8 strobe-triggered preset and snapshot
      wr(A_LOAD_LO, 32'h0B0A_0908);
      wr(A_LOAD_HI, 32'h0F0E_0D0C);
      strobe(1'b0, 1'b0, 1'b0, 1'b1, 1'b0);
      strobe(1'b0, 1'b0, 1'b0, 1'b0, 1'b1);
      rd(A_SNAP, v); chk("R8 busy after strobe", 64'(v), 64'h1);
      @(negedge clk);
      @(negedge clk);
      rd(A_SNAP, v); chk("R8 busy cleared after strobe", 64'(v), 64'h0);
      rd(A_SNAP_LO, lo);
      rd(A_SNAP_HI, hi);
      chk("R7 preset by strobe", {hi, lo}, 64'h0F0E_0D0C_0B0A_0908);

      repeat (4) @(negedge clk);
      chk("R5 all predicted alarms seen", 64'(exp_evt.size()), 64'h0);
      summary();
      $finish;
   end
endmodule